// File: doc/BRIEF.md
# Binary-Weighted LED Modulation Scheduler

This block generates the display timing for a multiplexed LED matrix driven by cascaded constant-current shift-register drivers. Brightness is produced by binary code modulation. Each segment is lit once for each active bit plane. Plane k is visible for a base period scaled by 2^k, and every bit cycle starts with a fixed blanking overhead in which new data is loaded. Time is counted in ticks, which are derived from the core clock by a divider.

At the start of every bit cycle the scheduler reads one 32-bit column word from an external frame memory. It shifts the word out on a mode-3 SPI master, then gives the drivers a one-tick latch pulse while the outputs are still blanked. After that it enables the outputs for the weighted part of the cycle. The bit-plane index counts up to a runtime-selected plane count. When it passes that count it returns to zero and the segment index advances.

Top module: `bcm_scheduler`

## Requirements
- R1: While running, bit cycle k holds `drv_oe_n` high for OVH_TICKS ticks from the cycle start (default 9). It then holds `drv_oe_n` low for BASE_TICKS·2^k ticks (default 4·2^k), and the next cycle follows at once. One tick is TICK_DIV clock cycles.
- R2: Planes run 0, 1, … up to nb−1 within a segment, after which the plane returns to 0 and the segment advances. After segment NUM_SEGS−1 the segment returns to 0. nb is `nbits`, with 0 treated as 1 and any value above MAX_PLANES treated as MAX_PLANES.
- R3: Exactly one frame-memory read is issued per bit cycle, as a single-clock `mem_rd_en` pulse in the first clock of the cycle, while outputs are blanked. The read address is plane·NUM_SEGS + segment, and the read data is taken on the following clock edge.
- R4: The fetched word is sent on SPI mode 3 as 32 bits, MSB first. That is two 16-bit frames back to back, the upper half first. `spi_sck` idles high, `spi_mosi` changes only when `spi_sck` falls and is sampled on its rising edge, and each bit lasts 2·SPI_HALF clocks.
- R5: `drv_strobe` is high for exactly one tick, starting STROBE_TICK ticks (default 8) after the read pulse, and is only ever high while `drv_oe_n` is high.
- R6: If the SPI transfer is not finished at the moment the strobe begins, `xfer_err` is set. It stays set until reset, including through disable and re-enable.
- R7: On the clock after `enable` is sampled low, `drv_oe_n` is high, `drv_strobe` and `mem_rd_en` are low, `spi_sck` is high, and no tick, plane or segment progress occurs. Raising `enable` again restarts at plane 0, segment 0.
- R8: During reset, `drv_oe_n` and `spi_sck` are high, and `spi_mosi`, `drv_strobe`, `mem_rd_en` and `xfer_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the scheduler; low stops and rewinds it |
| nbits | input | $clog2(MAX_PLANES+1) | Number of active bit planes |
| mem_rd_en | output | 1 | Frame-memory read strobe, one clock per bit cycle |
| mem_addr | output | $clog2(MAX_PLANES·NUM_SEGS) | Frame-memory word address |
| mem_rdata | input | DATA_W | Frame-memory read data, one clock after the read |
| spi_sck | output | 1 | SPI clock, idle high |
| spi_mosi | output | 1 | SPI serial data to the driver chain |
| drv_strobe | output | 1 | Driver latch pulse, one tick wide |
| drv_oe_n | output | 1 | Driver output enable, active low |
| xfer_err | output | 1 | Sticky flag: shift-out overran the latch time |

## Verification
The assertions check the following on every cycle: output enable and read activity stop one clock after `enable` drops; the SPI clock idles high whenever no transfer is in progress; data never changes except on a falling SPI clock; the strobe never overlaps lit outputs; the read pulse is a single blanked clock; the error flag is sticky; and the plane index stays in range. Only the bench scenarios can show the weighted lengths of the lit and blanked windows, the plane and segment order under different plane counts including the clamped ones, the exact serial word, the strobe delay, and the error raised by an instance whose SPI is too slow.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  // Ticks taken by bit cycle k: blank overhead plus weighted lit time.
  function automatic int unsigned cycle_ticks(input int unsigned ovh,
                                              input int unsigned base,
                                              input int unsigned k);
    return ovh + (base << k);
  endfunction

  // Counter width able to hold 0..n-1, at least one bit.
  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bcm_tick_gen.sv
module bcm_tick_gen #(
  parameter int unsigned TICK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = bcm_pkg::width_of(TICK_DIV);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             at_top;

  assign at_top = (pre_q == PRE_W'(TICK_DIV - 1));
  assign tick   = run && at_top;

  always_comb begin
    if (!run || restart || at_top) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/bcm_cycle_seq.sv
module bcm_cycle_seq #(
  parameter int unsigned NUM_SEGS    = 8,
  parameter int unsigned MAX_PLANES  = 10,
  parameter int unsigned OVH_TICKS   = 9,
  parameter int unsigned BASE_TICKS  = 4,
  parameter int unsigned STROBE_TICK = 8,
  parameter int unsigned NB_W        = 4,
  parameter int unsigned PL_W        = 4,
  parameter int unsigned SEG_W       = 3,
  parameter int unsigned CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [NB_W-1:0]  nbits,
  output logic             fetch,
  output logic             restart,
  output logic [PL_W-1:0]  plane,
  output logic [SEG_W-1:0] seg,
  output logic             oe_n,
  output logic             strobe,
  output logic             strobe_begin
);
  logic             active_q,  active_d;
  logic             fetch_q,   fetch_d;
  logic [CNT_W-1:0] cnt_q,     cnt_d;
  logic [PL_W-1:0]  plane_q,   plane_d;
  logic [SEG_W-1:0] seg_q,     seg_d;

  logic [NB_W-1:0]  nb_eff;
  logic [CNT_W-1:0] len_m1;
  logic             last_plane;
  logic             last_seg;
  logic             cyc_end;
  logic             start;

  // Plane count with zero raised to one and overlarge values clamped.
  always_comb begin
    if (nbits == '0) begin
      nb_eff = NB_W'(1);
    end else if (nbits > NB_W'(MAX_PLANES)) begin
      nb_eff = NB_W'(MAX_PLANES);
    end else begin
      nb_eff = nbits;
    end
  end

  assign len_m1     = CNT_W'(OVH_TICKS - 1) + (CNT_W'(BASE_TICKS) << plane_q);
  assign last_plane = (NB_W'(plane_q) + NB_W'(1)) >= nb_eff;
  assign last_seg   = (seg_q == SEG_W'(NUM_SEGS - 1));
  assign cyc_end    = active_q && tick && (cnt_q == len_m1);
  assign start      = run && (!active_q || cyc_end);

  always_comb begin
    active_d = active_q;
    fetch_d  = 1'b0;
    cnt_d    = cnt_q;
    plane_d  = plane_q;
    seg_d    = seg_q;
    if (!run) begin
      active_d = 1'b0;
      cnt_d    = '0;
      plane_d  = '0;
      seg_d    = '0;
    end else if (start) begin
      active_d = 1'b1;
      fetch_d  = 1'b1;
      cnt_d    = '0;
      if (cyc_end) begin
        if (last_plane) begin
          plane_d = '0;
          seg_d   = last_seg ? '0 : seg_q + SEG_W'(1);
        end else begin
          plane_d = plane_q + PL_W'(1);
        end
      end
    end else if (active_q && tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fetch_q  <= 1'b0;
      cnt_q    <= '0;
      plane_q  <= '0;
      seg_q    <= '0;
    end else begin
      active_q <= active_d;
      fetch_q  <= fetch_d;
      cnt_q    <= cnt_d;
      plane_q  <= plane_d;
      seg_q    <= seg_d;
    end
  end

  assign fetch        = fetch_q;
  assign restart      = start;
  assign plane        = plane_q;
  assign seg          = seg_q;
  assign oe_n         = !(active_q && (cnt_q >= CNT_W'(OVH_TICKS)));
  assign strobe       = active_q && (cnt_q == CNT_W'(STROBE_TICK));
  assign strobe_begin = active_q && tick && (cnt_q == CNT_W'(STROBE_TICK - 1));

endmodule

// File: rtl/bcm_spi_tx.sv
module bcm_spi_tx #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SPI_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              sck,
  output logic              mosi,
  output logic              busy
);
  localparam int unsigned DIV_W = bcm_pkg::width_of(SPI_HALF);
  localparam int unsigned BC_W  = bcm_pkg::width_of(DATA_W);

  logic              sck_q,  sck_d;
  logic              mosi_q, mosi_d;
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] sr_q,   sr_d;
  logic [DIV_W-1:0]  div_q,  div_d;
  logic [BC_W-1:0]   bc_q,   bc_d;
  logic              half_done;

  assign half_done = (div_q == DIV_W'(SPI_HALF - 1));

  always_comb begin
    sck_d  = sck_q;
    mosi_d = mosi_q;
    busy_d = busy_q;
    sr_d   = sr_q;
    div_d  = div_q;
    bc_d   = bc_q;
    if (!go) begin
      busy_d = 1'b0;
      sck_d  = 1'b1;
      div_d  = '0;
      bc_d   = '0;
    end else if (load) begin
      busy_d = 1'b1;
      sck_d  = 1'b1;
      div_d  = '0;
      bc_d   = '0;
      sr_d   = data;
    end else if (busy_q) begin
      if (half_done) begin
        div_d = '0;
        if (sck_q) begin
          // falling edge: present next bit
          sck_d  = 1'b0;
          mosi_d = sr_q[DATA_W-1];
          sr_d   = {sr_q[DATA_W-2:0], 1'b0};
        end else begin
          // rising edge: receiver samples
          sck_d = 1'b1;
          bc_d  = bc_q + BC_W'(1);
          if (bc_q == BC_W'(DATA_W - 1)) begin
            busy_d = 1'b0;
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b1;
      mosi_q <= 1'b0;
      busy_q <= 1'b0;
      sr_q   <= '0;
      div_q  <= '0;
      bc_q   <= '0;
    end else begin
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      busy_q <= busy_d;
      sr_q   <= sr_d;
      div_q  <= div_d;
      bc_q   <= bc_d;
    end
  end

  assign sck  = sck_q;
  assign mosi = mosi_q;
  assign busy = busy_q;

endmodule

// File: rtl/bcm_scheduler.sv
module bcm_scheduler #(
  parameter int unsigned NUM_SEGS    = 8,
  parameter int unsigned MAX_PLANES  = 10,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TICK_DIV    = 40,
  parameter int unsigned SPI_HALF    = 4,
  parameter int unsigned OVH_TICKS   = 9,
  parameter int unsigned BASE_TICKS  = 4,
  parameter int unsigned STROBE_TICK = 8,
  localparam int unsigned NB_W   = $clog2(MAX_PLANES + 1),
  localparam int unsigned ADDR_W = bcm_pkg::width_of(MAX_PLANES * NUM_SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NB_W-1:0]   nbits,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              drv_strobe,
  output logic              drv_oe_n,
  output logic              xfer_err
);
  localparam int unsigned PL_W  = bcm_pkg::width_of(MAX_PLANES);
  localparam int unsigned SEG_W = bcm_pkg::width_of(NUM_SEGS);
  localparam int unsigned CNT_W =
    $clog2(bcm_pkg::cycle_ticks(OVH_TICKS, BASE_TICKS, MAX_PLANES - 1) + 1);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             tick;
  logic             restart;
  logic             fetch;
  logic             strobe_begin;
  logic [PL_W-1:0]  plane_idx;
  logic [SEG_W-1:0] seg_idx;
  logic             spi_busy;
  logic             rvalid_q, rvalid_d;
  logic             err_q,    err_d;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  bcm_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) tick_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (enable),
    .restart (restart),
    .tick    (tick)
  );

  bcm_cycle_seq #(
    .NUM_SEGS    (NUM_SEGS),
    .MAX_PLANES  (MAX_PLANES),
    .OVH_TICKS   (OVH_TICKS),
    .BASE_TICKS  (BASE_TICKS),
    .STROBE_TICK (STROBE_TICK),
    .NB_W        (NB_W),
    .PL_W        (PL_W),
    .SEG_W       (SEG_W),
    .CNT_W       (CNT_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .run          (enable),
    .tick         (tick),
    .nbits        (nbits),
    .fetch        (fetch),
    .restart      (restart),
    .plane        (plane_idx),
    .seg          (seg_idx),
    .oe_n         (drv_oe_n),
    .strobe       (drv_strobe),
    .strobe_begin (strobe_begin)
  );

  bcm_spi_tx #(
    .DATA_W   (DATA_W),
    .SPI_HALF (SPI_HALF)
  ) spi_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .go    (enable),
    .load  (rvalid_q),
    .data  (mem_rdata),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .busy  (spi_busy)
  );

  assign mem_rd_en = fetch;
  assign mem_addr  = ADDR_W'(plane_idx) * ADDR_W'(NUM_SEGS) + ADDR_W'(seg_idx);

  always_comb begin
    rvalid_d = fetch && enable;
    err_d    = err_q;
    if (strobe_begin && (spi_busy || rvalid_q)) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign xfer_err = err_q;

endmodule

// File: rtl/bcm_scheduler_chk.sv
module bcm_scheduler_chk #(
  parameter int unsigned MAX_PLANES = 10,
  parameter int unsigned PL_W       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            mem_rd_en,
  input logic            spi_sck,
  input logic            spi_mosi,
  input logic            drv_strobe,
  input logic            drv_oe_n,
  input logic            xfer_err,
  input logic            spi_busy,
  input logic [PL_W-1:0] plane_idx
);

  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> drv_oe_n);                                     // R7

  AST_FETCH_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mem_rd_en);                                   // R7

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_busy |-> spi_sck);                                    // R4

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $fell(spi_sck));                    // R4

  AST_STROBE_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> drv_oe_n);                                  // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> xfer_err);                                    // R6

  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);                                 // R3

  AST_FETCH_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> drv_oe_n);                                   // R3

  AST_PLANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (int'(plane_idx) < int'(MAX_PLANES)));          // R2

endmodule

bind bcm_scheduler bcm_scheduler_chk #(
  .MAX_PLANES (MAX_PLANES),
  .PL_W       (PL_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .mem_rd_en  (mem_rd_en),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .drv_strobe (drv_strobe),
  .drv_oe_n   (drv_oe_n),
  .xfer_err   (xfer_err),
  .spi_busy   (spi_busy),
  .plane_idx  (plane_idx)
);

// File: tb/bcm_scheduler_tb_top.sv
`timescale 1ns/1ps
module bcm_scheduler_tb_top;
  localparam int NS   = 4;
  localparam int MAXP = 10;
  localparam int TD   = 10;
  localparam int OVH  = 9;
  localparam int BASE = 4;
  localparam int STB  = 8;
  localparam int DW   = 32;
  localparam int NBW  = $clog2(MAXP + 1);
  localparam int AW   = $clog2(MAXP * NS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic           enable;
  logic [NBW-1:0] nbits;

  logic          rd_a, sck_a, mosi_a, stb_a, oe_a, err_a;
  logic [AW-1:0] addr_a;
  logic [DW-1:0] rdata_a;
  logic          rd_b, sck_b, mosi_b, stb_b, oe_b, err_b;
  logic [AW-1:0] addr_b;
  logic [DW-1:0] rdata_b;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] v;
    v = 32'h9E3779B9 * DW'(a + 1);
    return v ^ 32'h0F0F1234;
  endfunction

  function automatic int nb_eff(input int nb);
    if (nb == 0) return 1;
    if (nb > MAXP) return MAXP;
    return nb;
  endfunction

  bcm_scheduler #(
    .NUM_SEGS(NS), .MAX_PLANES(MAXP), .DATA_W(DW), .TICK_DIV(TD), .SPI_HALF(1),
    .OVH_TICKS(OVH), .BASE_TICKS(BASE), .STROBE_TICK(STB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .nbits(nbits),
    .mem_rd_en(rd_a), .mem_addr(addr_a), .mem_rdata(rdata_a),
    .spi_sck(sck_a), .spi_mosi(mosi_a), .drv_strobe(stb_a),
    .drv_oe_n(oe_a), .xfer_err(err_a)
  );

  // Second instance whose shift-out is too slow for the strobe tick.
  bcm_scheduler #(
    .NUM_SEGS(NS), .MAX_PLANES(MAXP), .DATA_W(DW), .TICK_DIV(TD), .SPI_HALF(2),
    .OVH_TICKS(OVH), .BASE_TICKS(BASE), .STROBE_TICK(STB)
  ) slow_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .nbits(nbits),
    .mem_rd_en(rd_b), .mem_addr(addr_b), .mem_rdata(rdata_b),
    .spi_sck(sck_b), .spi_mosi(mosi_b), .drv_strobe(stb_b),
    .drv_oe_n(oe_b), .xfer_err(err_b)
  );

  always @(posedge clk) begin
    if (rd_a) rdata_a <= pat(int'(addr_a));
    if (rd_b) rdata_b <= pat(int'(addr_b));
  end

  // Scoreboard state
  int nb_cfg = 3;
  int exp_p, exp_s, cur_p, cur_addr;
  int low_len, high_len, stb_len, since_fetch, bits, nfetch = 0;
  bit had_low, in_high, prev_sck;
  logic [DW-1:0] sr;

  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      exp_p = 0; exp_s = 0; cur_p = 0; cur_addr = 0;
      low_len = 0; high_len = 0; stb_len = 0; since_fetch = 0; bits = 0;
      had_low = 0; in_high = 0; prev_sck = 1; sr = '0;
    end else begin
      // R1: blank and lit window lengths
      if (!oe_a) begin
        if (in_high && had_low)
          check(high_len == OVH * TD, "R1 blank window clocks", high_len, OVH * TD);
        in_high = 0; high_len = 0; low_len++;
      end else begin
        if (low_len > 0) begin
          check(low_len == (BASE << cur_p) * TD, "R1 lit window clocks", low_len, (BASE << cur_p) * TD);
          low_len = 0; had_low = 1;
        end
        in_high = 1; high_len++;
      end
      // R2/R3: address order
      if (rd_a) begin
        check(int'(addr_a) == exp_p * NS + exp_s, "R2 R3 fetch address", addr_a, exp_p * NS + exp_s);
        cur_p = exp_p; cur_addr = exp_p * NS + exp_s;
        if (exp_p + 1 >= nb_eff(nb_cfg)) begin
          exp_p = 0; exp_s = (exp_s + 1) % NS;
        end else begin
          exp_p++;
        end
        since_fetch = 0; bits = 0; nfetch++;
      end else begin
        since_fetch++;
      end
      // R5: strobe timing and width
      if (stb_a) begin
        if (stb_len == 0) begin
          check(since_fetch == STB * TD, "R5 strobe delay from read", since_fetch, STB * TD);
          check(bits == DW, "R4 bits shifted before strobe", bits, DW);
        end
        stb_len++;
      end else if (stb_len > 0) begin
        check(stb_len == TD, "R5 strobe width clocks", stb_len, TD);
        stb_len = 0;
      end
      // R4: serial word
      if (sck_a && !prev_sck) begin
        sr = {sr[DW-2:0], mosi_a};
        bits++;
        if (bits == DW)
          check(sr == pat(cur_addr), "R4 serial word", sr, pat(cur_addr));
      end
      prev_sck = sck_a;
    end
  end

  task automatic wait_fetch(input int n);
    int target;
    target = nfetch + n;
    while (nfetch < target) @(negedge clk);
  endtask

  task automatic run_phase(input int nb, input int nf);
    @(posedge clk); #1;
    nbits = NBW'(nb); nb_cfg = nb; enable = 1'b1;
    wait_fetch(nf);
    @(posedge clk); #1;
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 200000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int viol;
    rst_n = 1'b0; enable = 1'b0; nbits = NBW'(3);
    repeat (4) @(negedge clk);
    // R8 reset state
    check(oe_a == 1'b1,  "R8 oe_n in reset", oe_a, 1);
    check(sck_a == 1'b1, "R8 sck in reset", sck_a, 1);
    check(mosi_a == 1'b0 && stb_a == 1'b0 && rd_a == 1'b0, "R8 mosi strobe read in reset",
          {mosi_a, stb_a, rd_a}, 0);
    check(err_a == 1'b0, "R8 error in reset", err_a, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_phase(3, 13);
    check(err_b == 1'b1, "R6 slow transfer flags error", err_b, 1);
    run_phase(1, 9);
    run_phase(0, 5);   // R2 zero treated as one plane
    run_phase(2, 9);
    run_phase(15, 11); // R2 clamp to MAXP planes

    // R7 disable mid-cycle, then restart from plane 0 segment 0
    @(posedge clk); #1;
    nbits = NBW'(2); nb_cfg = 2; enable = 1'b1;
    wait_fetch(3);
    repeat (30) @(posedge clk);
    #1 enable = 1'b0;
    @(posedge clk);
    viol = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(oe_a && sck_a && !rd_a && !stb_a)) viol++;
    end
    check(viol == 0, "R7 outputs idle while disabled", viol, 0);
    @(posedge clk); #1 enable = 1'b1;
    @(negedge clk);
    while (!rd_a) @(negedge clk);
    check(addr_a == '0, "R7 restart address", addr_a, 0);
    wait_fetch(3);
    @(posedge clk); #1 enable = 1'b0;
    repeat (3) @(negedge clk);

    check(err_a == 1'b0, "R6 fast transfer leaves error clear", err_a, 0);
    check(err_b == 1'b1, "R6 error stays set after re-enable", err_b, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule